// File: doc/BRIEF.md
# Credit-Based Interrupt Moderator

This block moderates the interrupt traffic of a single descriptor ring. It keeps a count of the descriptors the device has completed that the host driver has not yet consumed. Each completion strobe adds one to that count. A host write to the credit register takes the written value away from it. The block decides whether to raise a one-cycle interrupt request, and tags each request with the message-signalled vector number that belongs to the ring.

An internal auto-mask limits the block to one outstanding interrupt at a time. The first completion seen while the ring is unmasked fires the request and sets the mask. Completions that arrive while the ring is masked only add to the count. When the driver returns credits, two cases follow. If the return empties the count, the ring unmasks without a new interrupt, because the driver has caught up. If work remains, the block fires again and the ring stays masked. This auto-mask is separate from the per-vector mask bit of the interrupt table, which lives outside the block together with the message write.

The ring kind and the ring index are parameters, and the vector number is derived from them. Returning more credits than are outstanding is a driver fault. In that case the count stops at zero and a sticky error flag is raised.

Top module: `irq_credit_mod`

## Requirements
- R1: A cycle with `done_i` high and no credit write makes `credits_o` one higher after the next clock edge. At the all-ones value the count holds.
- R2: A credit write of value N with `done_i` low makes `credits_o` lower by N after the next clock edge, provided N does not exceed the count.
- R3: While `masked_o` is low, a completion without a credit write produces an `irq_o` pulse of exactly one cycle after the next edge, and `masked_o` becomes high at that same edge.
- R4: While `masked_o` is high, completions without a credit write produce no `irq_o` pulse and leave `masked_o` high.
- R5: A credit write that leaves the count at zero clears `masked_o` and produces no `irq_o` pulse.
- R6: A credit write that leaves the count non-zero produces one `irq_o` pulse and leaves `masked_o` high. This includes a write of value 0.
- R7: `irq_vec_o` is fixed by parameters. Kind encoding 0 (command ring) gives vector 0, kind 1 (event ring) gives vector 1, kind 2 (test) gives vector 2, and kind 3 (data ring) gives vector 4 + RING_INDEX.
- R8: A credit write larger than the outstanding count sets `credits_o` to 0 and raises `ovr_err_o`. The flag stays high until reset. The ring then unmasks silently, as it does in R5.
- R9: When a completion and a credit write arrive in the same cycle, the increment is applied first. The subtraction, the overflow test and the zero test all see the incremented count.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `credits_o` is 0 and `masked_o`, `ovr_err_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| done_i | input | 1 | Device completed one descriptor of this ring |
| cred_wr_i | input | 1 | Host credit-return write strobe |
| cred_val_i | input | CNT_W | Number of credits returned by the write |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | VEC_W | Vector number carried with the request |
| credits_o | output | CNT_W | Outstanding credit count |
| masked_o | output | 1 | Auto-mask state |
| ovr_err_o | output | 1 | Sticky flag for a credit return beyond the count |

## Verification
The bench aims at the boundary between a full return and a partial return. A return that is off by one at that boundary would either swallow a needed re-fire or fire a spurious interrupt after the driver had caught up. A credit write of zero while work is pending is also exercised; a design that treated zero as "nothing happened" would leave the driver waiting forever. The bench also drives a completion and a credit write in the same cycle. There, a design that tested for zero before adding would unmask with one descriptor still pending. Finally, it drives over-returns: a design that wrapped the count instead of clamping it would report about four billion credits, and a design whose error flag was not sticky would lose the fault once the ring moved on.

// File: rtl/irq_credit_mod_pkg.sv
// Shared types for the credit-based interrupt moderator.
// Assumes message-signalled vectors of at most 8 bits.
package irq_credit_mod_pkg;

    // Ring kind; the encoding selects the vector mapping
    typedef enum logic [1:0] {
        RING_CMD  = 2'd0,
        RING_EVT  = 2'd1,
        RING_TEST = 2'd2,
        RING_DATA = 2'd3
    } ring_kind_e;

    // First vector number used by data rings
    localparam int DATA_VEC_BASE = 4;

endpackage

// File: rtl/irq_cred_counter.sv
// Outstanding-credit counter.
// Adds one per completion (holding at all-ones), then subtracts the returned
// credits. An over-return clamps the count to zero and sets a sticky error.
// Assumes at most one completion per cycle.
module irq_cred_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             err_o,
    output logic             nxt_zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bumped;
    logic [CNT_W-1:0] cnt_d;
    logic             under;
    logic             err_q;

    // Apply the completion before the credit return
    always_comb begin
        bumped = (done_i && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
        under  = wr_i && (val_i > bumped);
        if (!wr_i) begin
            cnt_d = bumped;
        end else if (under) begin
            cnt_d = '0;
        end else begin
            cnt_d = bumped - val_i;
        end
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Sticky over-return flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (under) begin
            err_q <= 1'b1;
        end
    end

    assign cnt_o      = cnt_q;
    assign err_o      = err_q;
    assign nxt_zero_o = (cnt_d == '0);
endmodule

// File: rtl/irq_automask.sv
// Auto-mask state and fire decision.
// A credit write either unmasks silently (count reaches zero) or re-fires
// and stays masked. Otherwise the first completion while unmasked fires and
// masks. Assumes nxt_zero_i already reflects the same-cycle completion.
module irq_automask (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic wr_i,
    input  logic nxt_zero_i,
    output logic fire_o,
    output logic mask_o
);
    logic mask_q;
    logic mask_d;
    logic fire_d;
    logic fire_q;

    // Decide the next mask state and whether to fire
    always_comb begin
        mask_d = mask_q;
        fire_d = 1'b0;
        if (wr_i) begin
            mask_d = !nxt_zero_i;
            fire_d = !nxt_zero_i;
        end else if (done_i && !mask_q) begin
            mask_d = 1'b1;
            fire_d = 1'b1;
        end
    end

    // Mask and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            mask_q <= mask_d;
            fire_q <= fire_d;
        end
    end

    assign fire_o = fire_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/irq_vec_map.sv
// Derives the ring's interrupt vector from its kind and index.
// Assumes 4 + RING_INDEX fits in VEC_W bits for data rings.
module irq_vec_map
    import irq_credit_mod_pkg::*;
#(
    parameter ring_kind_e RING_KIND  = RING_DATA,
    parameter int         RING_INDEX = 0,
    parameter int         VEC_W      = 8
) (
    output logic [VEC_W-1:0] vec_o
);
    // Select the mapping for this ring kind
    generate
        if (RING_KIND == RING_DATA) begin : g_data
            localparam int VNUM = DATA_VEC_BASE + RING_INDEX;
            assign vec_o = VNUM[VEC_W-1:0];
        end else begin : g_fixed
            localparam int VNUM = int'(RING_KIND);
            assign vec_o = VNUM[VEC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/irq_credit_mod.sv
// Credit-based interrupt moderator for one descriptor ring.
// Counts completed descriptors that the host has not yet consumed and
// raises a one-cycle request tagged with the ring's vector, under an
// internal auto-mask. Synchronous active-low reset.
module irq_credit_mod
    import irq_credit_mod_pkg::*;
#(
    parameter int         CNT_W      = 32,
    parameter int         VEC_W      = 8,
    parameter ring_kind_e RING_KIND  = RING_DATA,
    parameter int         RING_INDEX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             cred_wr_i,
    input  logic [CNT_W-1:0] cred_val_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o,
    output logic [CNT_W-1:0] credits_o,
    output logic             masked_o,
    output logic             ovr_err_o
);
    logic nxt_zero;

    irq_cred_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done_i),
        .wr_i       (cred_wr_i),
        .val_i      (cred_val_i),
        .cnt_o      (credits_o),
        .err_o      (ovr_err_o),
        .nxt_zero_o (nxt_zero)
    );

    irq_automask u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done_i),
        .wr_i       (cred_wr_i),
        .nxt_zero_i (nxt_zero),
        .fire_o     (irq_o),
        .mask_o     (masked_o)
    );

    irq_vec_map #(
        .RING_KIND  (RING_KIND),
        .RING_INDEX (RING_INDEX),
        .VEC_W      (VEC_W)
    ) u_vec (
        .vec_o (irq_vec_o)
    );
endmodule

// File: rtl/irq_credit_mod_chk.sv
// Protocol checker for irq_credit_mod, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module irq_credit_mod_chk #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_i,
    input logic             cred_wr_i,
    input logic [CNT_W-1:0] cred_val_i,
    input logic             irq_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic [CNT_W-1:0] credits_o,
    input logic             masked_o,
    input logic             ovr_err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] bump;

    // Count after a same-cycle completion, for the credit-write properties
    always_comb begin
        bump = (done_i && credits_o != CNT_MAX) ? credits_o + 1'b1 : credits_o;
    end

    p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !cred_wr_i && credits_o != CNT_MAX)
        |=> credits_o == $past(credits_o) + 1'b1);

    p_fire_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!masked_o && done_i && !cred_wr_i) |=> (irq_o && masked_o));

    p_quiet_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_o && !cred_wr_i) |=> (!irq_o && masked_o));

    p_full_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_wr_i && cred_val_i == bump) |=> (!irq_o && !masked_o && credits_o == '0));

    p_partial_refire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_wr_i && cred_val_i < bump) |=> (irq_o && masked_o));

    p_vec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(irq_vec_o));

    p_over_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_wr_i && cred_val_i > bump) |=> (ovr_err_o && credits_o == '0 && !irq_o));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err_o |=> ovr_err_o);

    p_irq_implies_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> masked_o);
endmodule

bind irq_credit_mod irq_credit_mod_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done_i),
    .cred_wr_i  (cred_wr_i),
    .cred_val_i (cred_val_i),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vec_o),
    .credits_o  (credits_o),
    .masked_o   (masked_o),
    .ovr_err_o  (ovr_err_o)
);

// File: tb/test_irq_credit_mod.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a reference model held in bench functions.
module test_irq_credit_mod;
    import irq_credit_mod_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic        cred_wr_i = 1'b0;
    logic [31:0] cred_val_i = '0;
    logic        irq_o;
    logic [7:0]  irq_vec_o;
    logic [31:0] credits_o;
    logic        masked_o;
    logic        ovr_err_o;

    logic        c_irq, c_mask, c_err;
    logic [7:0]  c_vec;
    logic [31:0] c_cred;

    int checks = 0;
    int errors = 0;

    int unsigned m_cnt  = 0;
    bit          m_mask = 1'b0;
    bit          m_err  = 1'b0;
    bit          m_irq  = 1'b0;

    always #5 clk = ~clk;

    irq_credit_mod #(.RING_KIND(RING_DATA), .RING_INDEX(3)) i_irq_credit_mod (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .cred_wr_i(cred_wr_i),
        .cred_val_i(cred_val_i), .irq_o(irq_o), .irq_vec_o(irq_vec_o),
        .credits_o(credits_o), .masked_o(masked_o), .ovr_err_o(ovr_err_o)
    );

    irq_credit_mod #(.RING_KIND(RING_EVT), .RING_INDEX(0)) i_irq_credit_mod_evt (
        .clk(clk), .rst_n(rst_n), .done_i(1'b0), .cred_wr_i(1'b0),
        .cred_val_i(32'd0), .irq_o(c_irq), .irq_vec_o(c_vec),
        .credits_o(c_cred), .masked_o(c_mask), .ovr_err_o(c_err)
    );

    function automatic int unsigned model_cnt(int unsigned cnt, bit d, bit wr, int unsigned val);
        int unsigned b = cnt + (d ? 1 : 0);
        if (!wr) return b;
        if (val > b) return 0;
        return b - val;
    endfunction

    function automatic bit model_fire(int unsigned nxt, bit mask, bit d, bit wr);
        if (wr) return nxt != 0;
        return d && !mask;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, advance the model, and sample at the following negedge
    task automatic step(bit d, bit wr, int unsigned val);
        int unsigned nxt;
        done_i = d; cred_wr_i = wr; cred_val_i = val;
        nxt    = model_cnt(m_cnt, d, wr, val);
        m_irq  = model_fire(nxt, m_mask, d, wr);
        if (wr && val > m_cnt + (d ? 1 : 0)) m_err = 1'b1;
        m_mask = wr ? (nxt != 0) : (m_mask | d);
        m_cnt  = nxt;
        @(posedge clk);
        @(negedge clk);
        done_i = 1'b0; cred_wr_i = 1'b0; cred_val_i = '0;
    endtask

    task automatic compare_all();
        check("R1/R2 credits", credits_o, m_cnt);
        check("R3/R6 irq", irq_o, m_irq);
        check("R4/R5 masked", masked_o, m_mask);
        check("R8 ovr_err", ovr_err_o, m_err);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_mask = 0; m_err = 0; m_irq = 0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog R10 actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        check("R10 credits", credits_o, 0);
        check("R10 masked", masked_o, 0);
        check("R10 err", ovr_err_o, 0);
        check("R10 irq", irq_o, 0);
        // R7: vector mapping, data ring 3 -> 7, event ring -> 1
        check("R7 data vector", irq_vec_o, 7);
        check("R7 event vector", c_vec, 1);

        // R3: first completion fires once and masks
        step(1, 0, 0);
        check("R3 irq", irq_o, 1); check("R3 masked", masked_o, 1);
        // R4: further completions stay quiet
        step(1, 0, 0); check("R4 irq", irq_o, 0);
        step(1, 0, 0); check("R4 irq", irq_o, 0);
        check("R1 credits", credits_o, 3);
        // R6: partial return re-fires
        step(0, 1, 1); check("R6 irq", irq_o, 1);
        check("R2 credits", credits_o, 2); check("R6 masked", masked_o, 1);
        // R6: return of zero with work pending re-fires
        step(0, 1, 0); check("R6 zero write irq", irq_o, 1);
        // R5: full return unmasks silently
        step(0, 1, 2); check("R5 irq", irq_o, 0);
        check("R5 masked", masked_o, 0); check("R5 credits", credits_o, 0);
        // R9: same-cycle completion and full return of 1 -> silent, unmasked
        step(1, 1, 1); check("R9 irq", irq_o, 0);
        check("R9 masked", masked_o, 0); check("R9 credits", credits_o, 0);
        // R9: same-cycle completion and zero write -> fires, count 1
        step(1, 1, 0); check("R9 irq fire", irq_o, 1); check("R9 count", credits_o, 1);
        // R8: over-return clamps and sets sticky error
        step(0, 1, 5); check("R8 credits", credits_o, 0);
        check("R8 err", ovr_err_o, 1); check("R8 irq", irq_o, 0);
        check("R8 masked", masked_o, 0);
        step(1, 0, 0); step(0, 1, 1);
        check("R8 sticky", ovr_err_o, 1);

        // Seeded random traffic against the model
        do_reset();
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            bit d  = ($urandom_range(0, 99) < 55);
            bit wr = ($urandom_range(0, 99) < 25);
            int unsigned v = $urandom_range(0, m_cnt + 2);
            if ($urandom_range(0, 99) < 70 && m_cnt > 0 && wr) v = $urandom_range(0, m_cnt);
            step(d, wr, v);
            compare_all();
        end

        // R10: reset clears the sticky flag
        do_reset();
        check("R10 err cleared", ovr_err_o, 0);
        check("R10 credits cleared", credits_o, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule